// File: doc/BRIEF.md
# Runt-Free Clock Output Enable Bank

This block fans one reference clock out to a bank of true/complement output pairs plus one feedback pair. Each output pair has one enable bit, taken from two 8-bit control bytes that a register file supplies. A pair whose bit is 0 is switched off and its pad drivers are released to high impedance. The feedback pair has no enable and always follows the reference clock.

An enable change never cuts a clock pulse short. The request is sampled at a falling edge of the reference clock, while the clock is low, and the change is applied at that edge.

- When a pair is switched off, its gate closes first. The pair is then driven low for one full cycle, and only after that is its drive enable removed.
- When a pair is switched on, its drive enable comes first. The pair is driven low for one full cycle, and only then do full-width pulses start.

Each `pin_oe` output goes to the pad as the tri-state control for its pair.

Top module: `clkbank_oe_bank`

## Requirements
- R1: Pair i (i = 0..7) is controlled by `ctl_byte0` bit i. Pairs 8 and 9 are controlled by `ctl_byte1` bits 0 and 1. `ctl_byte1` bits 7:2 have no effect on any output.
- R2: While `rst` is sampled high at a falling clock edge, every pair is put into the enabled state. After reset, all drive enables are 1 and all pairs toggle.
- R3: A pair whose enable bit has been 0 at two consecutive falling edges has `pin_oe` = 0 (high impedance), and both of its data lines are held at 0.
- R4: `fb_t` equals the reference clock and `fb_c` is its inverse at all times after reset, whatever the enable bytes hold.
- R5: While a pair's `pin_oe` is 1, its `pin_c` is the inverse of its `pin_t`.
- R6: When a falling edge samples an enable bit of 0 on a running pair, that pair produces no high phase from that edge on. Its `pin_oe` stays 1 until the next falling edge and then drops.
- R7: When a falling edge samples an enable bit of 1 on a stopped pair, its `pin_oe` rises at that edge and `pin_t` stays low for that whole cycle. Full pulses begin from the next falling edge.
- R8: A pair's `pin_t` is high only for complete high phases of the reference clock: it is either the clock or constant 0 within any one cycle.
- R9: A control-byte change made while the clock is high has no effect on any output before the next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock (also the timing base of the enable logic) |
| rst | input | 1 | Synchronous active-high reset, sampled at falling edges |
| ctl_byte0 | input | 8 | Enable bits for pairs 0..7 (1 = run) |
| ctl_byte1 | input | 8 | Bits 1:0 enable pairs 8..9; other bits unused |
| pin_t | output | 10 | True clock of each pair |
| pin_c | output | 10 | Complement clock of each pair |
| pin_oe | output | 10 | Drive enable of each pair (0 = high impedance) |
| fb_t | output | 1 | Feedback true clock, never disabled |
| fb_c | output | 1 | Feedback complement clock, never disabled |

## Verification
At every falling edge, the assertions check the ordering of each pair's gate and drive enable. The drive enable may only drop after a cycle in which the gate was already closed, and the gate may only open after a cycle in which the pair was already driven. They also tie the gate and the drive enable to the last two sampled request bits.

The pin-level behaviour can only be shown by the bench, which compares every pin against a reference model in mid-high and mid-low phases. This covers full-width pulses, complement tracking, the feedback pair, the bit mapping, ignored bits, and the insensitivity to changes made while the clock is high.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

    localparam int CTL_BYTE_W = 8;
    localparam int CTL_BYTES  = 2;
    localparam int CTL_BITS   = CTL_BYTE_W * CTL_BYTES;

    // Two-stage enable history of one pair, both stages updated at falling edges
    typedef struct packed {
        logic recent;   // request seen at the latest falling edge
        logic older;    // request seen one falling edge earlier
    } en_hist_t;

    typedef enum logic [1:0] {
        PS_OFF      = 2'b00,
        PS_STARTING = 2'b10,
        PS_STOPPING = 2'b01,
        PS_RUN      = 2'b11
    } pair_state_t;

    localparam en_hist_t HIST_RESET = '{recent: 1'b1, older: 1'b1};

    function automatic pair_state_t state_of(input en_hist_t h);
        return pair_state_t'({h.recent, h.older});
    endfunction

    // Gate is open only once the request has stood for two falling edges
    function automatic logic gate_open(input en_hist_t h);
        return state_of(h) == PS_RUN;
    endfunction

    // Pads are driven in every state except fully off
    function automatic logic drive_on(input en_hist_t h);
        return state_of(h) != PS_OFF;
    endfunction

    function automatic en_hist_t hist_step(input en_hist_t h, input logic req);
        en_hist_t n;
        n.recent = req;
        n.older  = h.recent;
        return n;
    endfunction

endpackage

// File: rtl/clkbank_req_map.sv
module clkbank_req_map
    import clkbank_pkg::*;
#(
    parameter int NUM_PAIRS = 10
) (
    input  logic [CTL_BYTE_W-1:0] byte_lo,
    input  logic [CTL_BYTE_W-1:0] byte_hi,
    output logic [NUM_PAIRS-1:0]  pair_req
);
    localparam int SPARE = CTL_BITS - NUM_PAIRS;

    logic [CTL_BITS-1:0] ctl_all;
    assign ctl_all = {byte_hi, byte_lo};

    // Pair i follows control bit i, counting from byte_lo bit 0
    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_map
        assign pair_req[i] = ctl_all[i];
    end

    if (SPARE > 0) begin : g_spare
        logic spare_unused;
        assign spare_unused = ^ctl_all[CTL_BITS-1:NUM_PAIRS];
    end
endmodule

// File: rtl/clkbank_gate_cell.sv
module clkbank_gate_cell
    import clkbank_pkg::*;
(
    input  logic clk_ref,
    input  logic rst,
    input  logic req,
    output logic gate,
    output logic drive
);
    en_hist_t hist_q;

    // Updates only at falling edges, i.e. while the clock is low
    always_ff @(negedge clk_ref) begin
        if (rst) hist_q <= HIST_RESET;
        else     hist_q <= hist_step(hist_q, req);
    end

    always_comb begin
        gate  = gate_open(hist_q);
        drive = drive_on(hist_q);
    end

    // R6
    drive_drop_after_idle_chk: assert property (@(negedge clk_ref) disable iff (rst)
        $fell(drive) |-> !$past(gate));

    // R7
    gate_open_after_drive_chk: assert property (@(negedge clk_ref) disable iff (rst)
        $rose(gate) |-> $past(drive));

    // R3
    off_after_two_zero_chk: assert property (@(negedge clk_ref) disable iff (rst)
        (!$past(req) && !$past(req, 2) && !$past(rst) && !$past(rst, 2)) |-> !drive);

    // R8
    gate_after_two_one_chk: assert property (@(negedge clk_ref) disable iff (rst)
        ($past(req) && $past(req, 2) && !$past(rst) && !$past(rst, 2)) |-> gate);
endmodule

// File: rtl/clkbank_pair_drv.sv
module clkbank_pair_drv (
    input  logic clk_ref,
    input  logic gate,
    input  logic drive,
    output logic out_t,
    output logic out_c,
    output logic out_oe
);
    logic gated_clk;

    always_comb begin
        gated_clk = clk_ref & gate;
        out_oe    = drive;
        out_t     = gated_clk;
        out_c     = drive & ~gated_clk;
    end
endmodule

// File: rtl/clkbank_oe_bank.sv
module clkbank_oe_bank
    import clkbank_pkg::*;
#(
    parameter int NUM_PAIRS = 10
) (
    input  logic                  clk_ref,
    input  logic                  rst,
    input  logic [CTL_BYTE_W-1:0] ctl_byte0,
    input  logic [CTL_BYTE_W-1:0] ctl_byte1,
    output logic [NUM_PAIRS-1:0]  pin_t,
    output logic [NUM_PAIRS-1:0]  pin_c,
    output logic [NUM_PAIRS-1:0]  pin_oe,
    output logic                  fb_t,
    output logic                  fb_c
);
    logic [NUM_PAIRS-1:0] pair_req;
    logic [NUM_PAIRS-1:0] pair_gate;
    logic [NUM_PAIRS-1:0] pair_drive;

    clkbank_req_map #(.NUM_PAIRS(NUM_PAIRS)) u_map (
        .byte_lo  (ctl_byte0),
        .byte_hi  (ctl_byte1),
        .pair_req (pair_req)
    );

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        clkbank_gate_cell u_cell (
            .clk_ref (clk_ref),
            .rst     (rst),
            .req     (pair_req[i]),
            .gate    (pair_gate[i]),
            .drive   (pair_drive[i])
        );
        clkbank_pair_drv u_drv (
            .clk_ref (clk_ref),
            .gate    (pair_gate[i]),
            .drive   (pair_drive[i]),
            .out_t   (pin_t[i]),
            .out_c   (pin_c[i]),
            .out_oe  (pin_oe[i])
        );
    end

    // Feedback pair has no gate and no enable
    always_comb begin
        fb_t = clk_ref;
        fb_c = ~clk_ref;
    end
endmodule

// File: tb/clkbank_oe_bank_test.sv
`timescale 1ns/1ps
module clkbank_oe_bank_test;
    localparam int  NP     = 10;
    localparam time PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] b0 = 8'hFF;
    logic [7:0] b1 = 8'hFF;
    logic [NP-1:0] pt, pc, poe;
    logic ft, fc;

    int errors = 0;
    int checks = 0;
    bit comparing = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    clkbank_oe_bank #(.NUM_PAIRS(NP)) uut (
        .clk_ref(clk), .rst(rst), .ctl_byte0(b0), .ctl_byte1(b1),
        .pin_t(pt), .pin_c(pc), .pin_oe(poe), .fb_t(ft), .fb_c(fc)
    );

    // Reference model: queue of requests seen at falling edges, newest first
    bit [NP-1:0] seen[$];
    always @(negedge clk) begin
        bit [15:0] both;
        both = {b1, b0};
        if (rst) begin
            seen.delete();
            seen.push_front('1);
            seen.push_front('1);
        end else begin
            seen.push_front(both[NP-1:0]);
            if (seen.size() > 2) void'(seen.pop_back());
        end
    end

    task automatic chk(input string tag, input int idx, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pair %0d at %0t: actual=%b expected=%b", tag, idx, $time, act, exp);
        end
    endtask

    task automatic compare(input bit lvl);
        for (int i = 0; i < NP; i++) begin
            bit now_r, prev_r, eg, eo, et, ec;
            string otag;
            now_r  = seen[0][i];
            prev_r = seen[1][i];
            eg = now_r && prev_r;
            eo = now_r || prev_r;
            et = lvl && eg;
            ec = eo ? !et : 1'b0;
            otag = !eo ? "R3" : (now_r && !prev_r) ? "R7" : (!now_r && prev_r) ? "R6" : "R2";
            chk(otag, i, poe[i], eo);
            chk("R8", i, pt[i], et);
            chk(eo ? "R5" : "R3", i, pc[i], ec);
        end
        chk("R4", -1, ft, lvl);
        chk("R4", -1, fc, !lvl);
    endtask

    initial forever begin
        @(posedge clk); #2;
        if (comparing) compare(1'b1);
        @(negedge clk); #2;
        if (comparing) compare(1'b0);
    end

    task automatic set_bytes(input logic [7:0] lo, input logic [7:0] hi);
        @(posedge clk); #1;
        b0 = lo; b1 = hi;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #2;
        for (int i = 0; i < NP; i++) begin
            chk("R2", i, poe[i], 1'b1);
            chk("R2", i, pt[i], 1'b1);
        end
        comparing = 1;
        idle(4);
        // single pair off then on
        set_bytes(8'hF7, 8'hFF); idle(5);
        set_bytes(8'hFF, 8'hFF); idle(5);
        // R1: upper bits of byte1 have no effect, pairs 8/9 follow bits 1:0
        set_bytes(8'hFF, 8'h03); idle(4);
        @(negedge clk); #3;
        chk("R1", 8, poe[8], 1'b1); chk("R1", 9, poe[9], 1'b1);
        set_bytes(8'hFF, 8'hFC); idle(4);
        @(negedge clk); #3;
        chk("R1", 8, poe[8], 1'b0); chk("R1", 9, poe[9], 1'b0);
        chk("R1", 0, poe[0], 1'b1);
        set_bytes(8'h01, 8'h02); idle(4);
        @(negedge clk); #3;
        for (int i = 0; i < NP; i++)
            chk("R1", i, poe[i], (i == 0 || i == 9) ? 1'b1 : 1'b0);
        // R9: change in high phase is not visible before the falling edge
        set_bytes(8'hFF, 8'hFF);
        #1;
        chk("R9", 1, poe[1], 1'b0);
        chk("R9", 1, pt[1], 1'b0);
        idle(4);
        // all off, then alternating toggles every cycle
        set_bytes(8'h00, 8'h00); idle(4);
        for (int k = 0; k < 8; k++) set_bytes(8'h55 ^ {8{k[0]}}, 8'h01 ^ {8{k[0]}});
        // pseudo-random patterns
        lfsr = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            set_bytes(lfsr[7:0], lfsr[15:8]);
            if (lfsr[3]) idle(2);
        end
        // R2: reset in the middle of activity restores all outputs
        set_bytes(8'h00, 8'h00); idle(3);
        comparing = 0;
        @(posedge clk); #1 rst = 1'b1;
        repeat (2) @(negedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #2;
        for (int i = 0; i < NP; i++) chk("R2", i, poe[i], 1'b1);
        comparing = 1;
        idle(6);
        finish_run();
    end
endmodule